// File: doc/BRIEF.md
# Sequential Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point numbers in the common single-precision interchange format. The most significant bit of each word is the sign, the next eight bits are an exponent biased by 127, and the low 23 bits are the fraction. Each operand is split into its fields and the hidden leading one is put back. The two 24-bit significands are then multiplied by an iterative radix-2 Booth-recoded shift-add engine, which retires one multiplier bit per clock. In parallel, the exponents are combined as E1 + E2 − 127 and the sign is taken as the XOR of the operand signs. The 48-bit significand product is normalised so that it has a single leading one, the surplus fraction bits are dropped (truncation toward zero), and the result is packed.

A client raises `start_i` for one cycle with both operands present. The block accepts the request only when no earlier operation is still outstanding. Later it raises `done_o` for exactly one cycle, with the result and the overflow and underflow flags valid. These outputs hold until the next `done_o`. If either operand is zero, the block skips the Booth iterations and answers in a single cycle. The block does not handle subnormal inputs, NaN payloads or rounding modes other than truncation.

Top module: `fp32_mul_seq`

## Requirements
- R1: While `rst_n` is low, `result_o` is 0 and `done_o`, `overflow_o` and `underflow_o` are 0.
- R2: The result sign (bit 31) is the XOR of the operand sign bits. The exponent sits in bits 30:23 and the fraction in bits 22:0, for both operands and result.
- R3: For non-zero operands, the result exponent is E1 + E2 − 127. When the product of the two significands (each 1.fraction) is 2 or more, the result exponent is one higher and the significand product is shifted right by one.
- R4: The 23 result fraction bits are the bits directly below the leading one of the normalised product. All lower bits are discarded, so the result is truncated toward zero.
- R5: If the final biased exponent is 255 or more, the result is {sign, 8'hFF, 23'h0}, `overflow_o` is 1 and `underflow_o` is 0.
- R6: If the final biased exponent is 0 or less, the result is {sign, 31'h0}, `underflow_o` is 1 and `overflow_o` is 0.
- R7: If either operand has bits 30:0 all zero, the result is {sign, 31'h0} with both flags 0. `done_o` is high in the cycle right after the accepting clock edge.
- R8: For non-zero operands, `done_o` is high for one cycle, starting 26 clock edges after the accepting edge. The result and flags are valid while `done_o` is high and hold until the next `done_o`.
- R9: A `start_i` sampled on any edge from the one after an accepting edge up to and including the edge that raises `done_o` is ignored, and the operand values on such edges have no effect on any result.
- R10: 0xC1940000 (−18.5) times 0x41180000 (9.5) gives 0xC32FC000 (−175.75).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| start_i | input | 1 | Request to multiply the present operands |
| op_a_i | input | 32 | First operand, single-precision word |
| op_b_i | input | 32 | Second operand, single-precision word |
| result_o | output | 32 | Product, single-precision word |
| done_o | output | 1 | One-cycle pulse: result and flags valid |
| overflow_o | output | 1 | Result exponent too large, infinity returned |
| underflow_o | output | 1 | Result exponent too small, signed zero returned |

## Verification
Two things can land on the same clock edge: completion of a Booth-based product and a new request, including a zero-operand request whose one-cycle answer would also want to drive `done_o` on that edge. The bench provokes this by holding `start_i` high through an entire non-zero operation, with a zero operand presented on the completion edge. A behavioural model decides, edge by edge, whether each request is taken. The bench then compares `done_o`, the result and both flags against the model on every cycle. Any merged, dropped or doubled pulse, or a result taken from the wrong operands, shows up as a mismatch.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int unsigned FP_EXP_W  = 8;
  localparam int unsigned FP_FRAC_W = 23;
  localparam int unsigned FP_W      = 1 + FP_EXP_W + FP_FRAC_W;
  localparam int unsigned FP_SIG_W  = FP_FRAC_W + 1;
  localparam int unsigned FP_EXPC_W = FP_EXP_W + 2;
endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack #(
  parameter int unsigned EXP_W  = fpm_pkg::FP_EXP_W,
  parameter int unsigned FRAC_W = fpm_pkg::FP_FRAC_W,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W,
  localparam int unsigned SIG_W = FRAC_W + 1
) (
  input  logic [W-1:0]     word_i,
  output logic             sign_o,
  output logic [EXP_W-1:0] expo_o,
  output logic [SIG_W-1:0] sig_o,
  output logic             zero_o
);
  logic [FRAC_W-1:0] frac;
  logic              hidden;

  always_comb begin
    sign_o = word_i[W-1];
    expo_o = word_i[W-2 -: EXP_W];
    frac   = word_i[FRAC_W-1:0];
    hidden = |expo_o;
    sig_o  = {hidden, frac};
    zero_o = ~hidden & ~(|frac);
  end
endmodule

// File: rtl/fpm_booth_core.sv
module fpm_booth_core #(
  parameter int unsigned SIG_W = fpm_pkg::FP_SIG_W,
  localparam int unsigned STEPS  = SIG_W + 1,
  localparam int unsigned MPLR_W = SIG_W + 1,
  localparam int unsigned ACC_W  = SIG_W + 3,
  localparam int unsigned CNT_W  = $clog2(STEPS),
  localparam int unsigned PROD_W = 2 * SIG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [SIG_W-1:0]  mcand_i,
  input  logic [SIG_W-1:0]  mplr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [PROD_W-1:0] prod_o
);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(STEPS - 1);

  logic [ACC_W-1:0]  acc_q, acc_d, addend;
  logic [MPLR_W-1:0] mplr_q, mplr_d;
  logic [SIG_W-1:0]  mcand_q, mcand_d;
  logic [ACC_W-1:0]  mcand_ext;
  logic              qm1_q, qm1_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic              dp_en;
  logic [ACC_W+MPLR_W-1:0] full_prod;

  assign mcand_ext = ACC_W'(mcand_q);
  assign dp_en     = start_i | busy_q;

  // recode the current multiplier bit pair and step the partial product
  always_comb begin
    unique case ({mplr_q[0], qm1_q})
      2'b01:   addend = acc_q + mcand_ext;
      2'b10:   addend = acc_q - mcand_ext;
      default: addend = acc_q;
    endcase
  end

  always_comb begin
    acc_d   = acc_q;
    mplr_d  = mplr_q;
    qm1_d   = qm1_q;
    mcand_d = mcand_q;
    cnt_d   = cnt_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    if (start_i) begin
      acc_d   = '0;
      mplr_d  = MPLR_W'(mplr_i);
      qm1_d   = 1'b0;
      mcand_d = mcand_i;
      cnt_d   = '0;
      busy_d  = 1'b1;
    end else if (busy_q) begin
      acc_d  = {addend[ACC_W-1], addend[ACC_W-1:1]};
      mplr_d = {addend[0], mplr_q[MPLR_W-1:1]};
      qm1_d  = mplr_q[0];
      if (cnt_q == LAST_STEP) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      mplr_q  <= '0;
      qm1_q   <= 1'b0;
      mcand_q <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      if (dp_en) begin
        acc_q   <= acc_d;
        mplr_q  <= mplr_d;
        qm1_q   <= qm1_d;
        mcand_q <= mcand_d;
        cnt_q   <= cnt_d;
        busy_q  <= busy_d;
      end
    end
  end

  assign full_prod = {acc_q, mplr_q};
  assign prod_o    = full_prod[PROD_W-1:0];
  assign busy_o    = busy_q;
  assign done_o    = done_q;

  // R8: step counter never passes the last Booth step
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= LAST_STEP));
  // R8: completion pulse only directly after a busy cycle
  p_done_from_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(busy_q) && !busy_q));
  // R3: the product of two unsigned significands is never negative
  p_prod_nonneg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !acc_q[ACC_W-1]);
  // R9: the controller never restarts a running iteration
  p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_q);
endmodule

// File: rtl/fpm_pack.sv
module fpm_pack #(
  parameter int unsigned EXP_W  = fpm_pkg::FP_EXP_W,
  parameter int unsigned FRAC_W = fpm_pkg::FP_FRAC_W,
  parameter int unsigned EXPC_W = fpm_pkg::FP_EXPC_W,
  localparam int unsigned W      = 1 + EXP_W + FRAC_W,
  localparam int unsigned SIG_W  = FRAC_W + 1,
  localparam int unsigned PROD_W = 2 * SIG_W
) (
  input  logic                     sign_i,
  input  logic signed [EXPC_W-1:0] expc_i,
  input  logic [PROD_W-1:0]        prod_i,
  output logic [W-1:0]             word_o,
  output logic                     ovf_o,
  output logic                     unf_o
);
  localparam logic signed [EXPC_W-1:0] EXP_TOP = EXPC_W'((1 << EXP_W) - 1);

  logic                     carry_top;
  logic [FRAC_W-1:0]        frac;
  logic signed [EXPC_W-1:0] exp_fin;

  always_comb begin
    carry_top = prod_i[PROD_W-1];
    if (carry_top) begin
      frac = prod_i[PROD_W-2 -: FRAC_W];
    end else begin
      frac = prod_i[PROD_W-3 -: FRAC_W];
    end
    exp_fin = expc_i + $signed({{(EXPC_W-1){1'b0}}, carry_top});
    ovf_o   = 1'b0;
    unf_o   = 1'b0;
    if (!exp_fin[EXPC_W-1] && (exp_fin >= EXP_TOP)) begin
      ovf_o  = 1'b1;
      word_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (exp_fin[EXPC_W-1] || (exp_fin == '0)) begin
      unf_o  = 1'b1;
      word_o = {sign_i, {(W-1){1'b0}}};
    end else begin
      word_o = {sign_i, exp_fin[EXP_W-1:0], frac};
    end
  end
endmodule

// File: rtl/fp32_mul_seq.sv
module fp32_mul_seq #(
  parameter int unsigned EXP_W  = fpm_pkg::FP_EXP_W,
  parameter int unsigned FRAC_W = fpm_pkg::FP_FRAC_W,
  localparam int unsigned W      = 1 + EXP_W + FRAC_W,
  localparam int unsigned SIG_W  = FRAC_W + 1,
  localparam int unsigned PROD_W = 2 * SIG_W,
  localparam int unsigned EXPC_W = EXP_W + 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  output logic [W-1:0] result_o,
  output logic         done_o,
  output logic         overflow_o,
  output logic         underflow_o
);
  localparam logic signed [EXPC_W-1:0] BIAS = EXPC_W'((1 << (EXP_W - 1)) - 1);

  logic [1:0][W-1:0]     op_word;
  logic [1:0]            op_sign;
  logic [1:0][EXP_W-1:0] op_expo;
  logic [1:0][SIG_W-1:0] op_sig;
  logic [1:0]            op_zero;

  assign op_word[0] = op_a_i;
  assign op_word[1] = op_b_i;

  for (genvar g = 0; g < 2; g++) begin : g_unpack
    fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
      .word_i (op_word[g]),
      .sign_o (op_sign[g]),
      .expo_o (op_expo[g]),
      .sig_o  (op_sig[g]),
      .zero_o (op_zero[g])
    );
  end

  logic                     core_busy, core_done, core_start;
  logic [PROD_W-1:0]        core_prod;
  logic                     accept, any_zero, sign_new;
  logic signed [EXPC_W-1:0] exp_new;
  logic                     sign_q, sign_d;
  logic signed [EXPC_W-1:0] exp_q, exp_d;
  logic [W-1:0]             res_q, res_d, pack_word;
  logic                     ovf_q, ovf_d, unf_q, unf_d, done_q, done_d;
  logic                     pack_ovf, pack_unf, op_en, out_en;

  fpm_booth_core #(.SIG_W(SIG_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (core_start),
    .mcand_i (op_sig[0]),
    .mplr_i  (op_sig[1]),
    .busy_o  (core_busy),
    .done_o  (core_done),
    .prod_o  (core_prod)
  );

  fpm_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .EXPC_W(EXPC_W)) u_pack (
    .sign_i (sign_q),
    .expc_i (exp_q),
    .prod_i (core_prod),
    .word_o (pack_word),
    .ovf_o  (pack_ovf),
    .unf_o  (pack_unf)
  );

  // request gating, exponent combination and output selection
  always_comb begin
    accept     = start_i & ~core_busy & ~core_done;
    any_zero   = |op_zero;
    sign_new   = op_sign[0] ^ op_sign[1];
    exp_new    = $signed({2'b00, op_expo[0]}) + $signed({2'b00, op_expo[1]}) - BIAS;
    core_start = accept & ~any_zero;
    op_en      = core_start;
    out_en     = core_done | (accept & any_zero);
    sign_d     = sign_new;
    exp_d      = exp_new;
    done_d     = out_en;
    if (core_done) begin
      res_d = pack_word;
      ovf_d = pack_ovf;
      unf_d = pack_unf;
    end else begin
      res_d = {sign_new, {(W-1){1'b0}}};
      ovf_d = 1'b0;
      unf_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sign_q <= 1'b0;
      exp_q  <= '0;
      res_q  <= '0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (op_en) begin
        sign_q <= sign_d;
        exp_q  <= exp_d;
      end
      if (out_en) begin
        res_q <= res_d;
        ovf_q <= ovf_d;
        unf_q <= unf_d;
      end
    end
  end

  assign result_o    = res_q;
  assign done_o      = done_q;
  assign overflow_o  = ovf_q;
  assign underflow_o = unf_q;

  // R5: overflow always comes with the infinity encoding
  p_ovf_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |-> (result_o[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));
  // R6: underflow always comes with a signed zero
  p_unf_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |-> (result_o[W-2:0] == '0));
  // R5: the two range flags never appear together
  p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(overflow_o && underflow_o));
  // R8: every finished product is presented on the next cycle
  p_done_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |=> done_o);
  // R9: a request during a running product leaves the latched fields alone
  p_hold_fields_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (core_busy && start_i) |=> ($stable(sign_q) && $stable(exp_q)));
endmodule

// File: tb/fp32_mul_seq_test.sv
module fp32_mul_seq_test;
  localparam int LAT = 26;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] op_a_i = '0;
  logic [31:0] op_b_i = '0;
  logic [31:0] result_o;
  logic        done_o, overflow_o, underflow_o;

  fp32_mul_seq uut (
    .clk (clk), .rst_n (rst_n), .start_i (start_i),
    .op_a_i (op_a_i), .op_b_i (op_b_i), .result_o (result_o),
    .done_o (done_o), .overflow_o (overflow_o), .underflow_o (underflow_o)
  );

  always #5 clk = ~clk;

  int    n_chk = 0;
  int    n_err = 0;
  int    cyc = 0;
  bit    finished = 1'b0;
  string cur_req = "R1";

  // behavioural model state
  int          m_cnt;
  logic        m_done, m_ovf, m_unf, p_ovf, p_unf, p_z;
  logic [31:0] m_res, p_res;
  string       m_tag;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic void ref_mul(input logic [31:0] a, input logic [31:0] b,
                                  output logic [31:0] r, output logic ov,
                                  output logic un, output logic z);
    longint unsigned ma, mb, p;
    int              e;
    logic            s;
    logic [22:0]     frac;
    s  = a[31] ^ b[31];
    ov = 1'b0;
    un = 1'b0;
    z  = (a[30:0] == 31'h0) || (b[30:0] == 31'h0);
    r  = {s, 31'h0};
    if (z) return;
    ma = {40'h0, (a[30:23] != 8'h0), a[22:0]};
    mb = {40'h0, (b[30:23] != 8'h0), b[22:0]};
    p  = ma * mb;
    e  = int'(a[30:23]) + int'(b[30:23]) - 127;
    if (p[47]) begin
      e++;
      frac = p[46:24];
    end else begin
      frac = p[45:23];
    end
    if (e >= 255) begin
      ov = 1'b1;
      r  = {s, 8'hFF, 23'h0};
    end else if (e <= 0) begin
      un = 1'b1;
    end else begin
      r = {s, 8'(e), frac};
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_done = 1'b0; m_res = '0; m_ovf = 1'b0; m_unf = 1'b0;
      m_tag = "R1";
    end else begin
      m_done = 1'b0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_done = 1'b1; m_res = p_res; m_ovf = p_ovf; m_unf = p_unf;
        end
      end else if (start_i) begin
        ref_mul(op_a_i, op_b_i, p_res, p_ovf, p_unf, p_z);
        m_tag = cur_req;
        if (p_z) begin
          m_done = 1'b1; m_res = p_res; m_ovf = 1'b0; m_unf = 1'b0;
        end else begin
          m_cnt = LAT;
        end
      end
    end
  end

  // compare against the model on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(done_o == m_done, m_tag, "done", 32'(done_o), 32'(m_done));
      chk(result_o == m_res, m_tag, "result", result_o, m_res);
      chk(overflow_o == m_ovf, m_tag, "overflow", 32'(overflow_o), 32'(m_ovf));
      chk(underflow_o == m_unf, m_tag, "underflow", 32'(underflow_o), 32'(m_unf));
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (m_cnt != 0 || m_done) @(negedge clk);
  endtask

  task automatic run(input logic [31:0] a, input logic [31:0] b, input string req);
    @(negedge clk);
    cur_req = req;
    op_a_i  = a;
    op_b_i  = b;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    op_a_i  = $urandom;
    op_b_i  = $urandom;
    wait_idle();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000 && !finished) begin
      finished = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL R8 watchdog: actual=%0d expected=<%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(result_o == 32'h0, "R1", "reset result", result_o, 32'h0);
    chk(done_o == 1'b0, "R1", "reset done", 32'(done_o), 32'h0);
    chk(overflow_o == 1'b0, "R1", "reset overflow", 32'(overflow_o), 32'h0);
    chk(underflow_o == 1'b0, "R1", "reset underflow", 32'(underflow_o), 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R10: worked example
    run(32'hC1940000, 32'h41180000, "R10");
    chk(result_o == 32'hC32FC000, "R10", "example", result_o, 32'hC32FC000);
    // R2: sign combinations
    run(32'h41180000, 32'hC1940000, "R2");
    run(32'hC1940000, 32'hC1180000, "R2");
    run(32'h3F800000, 32'h3F800000, "R2");
    chk(result_o == 32'h3F800000, "R2", "one times one", result_o, 32'h3F800000);
    // R3: normalisation shift
    run(32'h3FC00000, 32'h3FC00000, "R3");
    chk(result_o == 32'h40100000, "R3", "1.5 squared", result_o, 32'h40100000);
    run(32'h40000000, 32'h3F000000, "R3");
    // R4: truncation of discarded bits
    run(32'h3F800001, 32'h3F800001, "R4");
    chk(result_o == 32'h3F800002, "R4", "truncate", result_o, 32'h3F800002);
    run(32'h3FFFFFFF, 32'h3FFFFFFF, "R4");
    chk(result_o == 32'h407FFFFE, "R4", "truncate max", result_o, 32'h407FFFFE);
    // R5: overflow
    run(32'h7F000000, 32'h40000000, "R5");
    chk(result_o == 32'h7F800000 && overflow_o, "R5", "overflow", result_o, 32'h7F800000);
    run(32'hFF7FFFFF, 32'h7F7FFFFF, "R5");
    run(32'h7F000000, 32'h3FFFFFFF, "R5");
    // R6: underflow
    run(32'h00800000, 32'h3F000000, "R6");
    chk(result_o == 32'h0 && underflow_o, "R6", "underflow", result_o, 32'h0);
    run(32'h80800000, 32'h00800000, "R6");
    run(32'h00800000, 32'h3FFFFFFF, "R6");
    // R7: zero operands
    run(32'h00000000, 32'h7F7FFFFF, "R7");
    run(32'h3F800000, 32'h80000000, "R7");
    chk(result_o == 32'h80000000, "R7", "signed zero", result_o, 32'h80000000);
    @(negedge clk);
    cur_req = "R7";
    op_a_i = 32'h80000000; op_b_i = 32'h40400000; start_i = 1'b1;
    repeat (4) @(negedge clk);
    start_i = 1'b0;
    wait_idle();
    // R9: request held through a whole product; zero operand on the completion edge
    @(negedge clk);
    cur_req = "R9";
    op_a_i = 32'h40490FDB; op_b_i = 32'hC0000001; start_i = 1'b1;
    @(negedge clk);
    op_a_i = 32'h80000000; op_b_i = 32'h41200000;
    repeat (LAT + 3) @(negedge clk);
    start_i = 1'b0;
    wait_idle();
    @(negedge clk);
    cur_req = "R9";
    op_a_i = 32'h3FC00000; op_b_i = 32'h3FC00000; start_i = 1'b1;
    @(negedge clk);
    op_a_i = 32'h7F000000; op_b_i = 32'h7F000000;
    repeat (LAT + 1) @(negedge clk);
    start_i = 1'b0;
    wait_idle();
    // R8: mixed values, latency and hold checked each cycle
    for (int i = 0; i < 24; i++) begin
      logic [7:0] ea, eb;
      ea = 8'($urandom_range(64, 190));
      eb = 8'($urandom_range(64, 190));
      run({1'($urandom_range(0, 1)), ea, 23'($urandom)},
          {1'($urandom_range(0, 1)), eb, 23'($urandom)}, "R8");
    end
    repeat (5) @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule